// File: doc/BRIEF.md
# UART Receive Service Arbiter

This block decides, cycle by cycle, how the receive FIFO of a FIFO-based UART is emptied. The FIFO can be emptied by a DMA engine, by interrupt-driven programmed I/O, or by both. Its inputs are:

- a five-bit interrupt enable word;
- a DMA enable;
- the FIFO fill level and the trigger threshold;
- push and pop strobes with the error flags (parity, framing, break) of the entry being written and of the entry at the read side;
- a character-timeout strobe;
- the transmit-empty and modem-change conditions of the rest of the UART.

From these it drives a receive DMA request, one interrupt line and a four-bit code that names the highest-priority pending source.

The block keeps a running count of FIFO entries that carry an error. From that count it derives the FIFO error summary. While the summary is set, DMA requests stop. If DMA is enabled, the summary also raises an error interrupt that software cannot mask, which hands the FIFO back to programmed I/O. A character timeout is latched as a source of its own, separate from data-available. It also blocks DMA until a pop drains the FIFO by software. All outputs are registered.

Top module: `uart_rx_svc`

## Requirements
- R1: While reset is active and in the first cycles after its release, dma_req and irq are 0, int_id is 4'h1 (none pending) and rx_err_sum is 0.
- R2: dma_req is 1 exactly one clock after a cycle in which dma_en is 1, fifo_level >= trig_level, rx_err_sum is 0 and no timeout is pending. It is 0 one clock after any of these fails.
- R3: rx_err_sum becomes 1 one clock after a push whose push_flags is nonzero. It stays 1 while any error entry remains, and returns to 0 one clock after the pop that removes the last such entry (a pop with nonzero head_flags).
- R4: The line-status source (int_en bit 2) is active only when the head entry is erroneous (head_flags nonzero and fifo_level nonzero). An error entry that is pushed but not yet at the head raises nothing while dma_en is 0.
- R5: With dma_en 1 and rx_err_sum 1, irq is 1 and int_id is 4'h6 one clock later, whatever the value of int_en.
- R6: A char_to strobe sets a pending timeout that a pop clears; if both occur in the same cycle, the timeout stays pending. While the timeout is pending, dma_req is 0, and with int_en bit 4 set the source reports code 4'hC.
- R7: int_id names the highest pending source in this order: line status or error (4'h6), data available (4'h4), timeout (4'hC), transmit empty (4'h2), modem change (4'h0). It is 4'h1 when none is pending.
- R8: irq, registered, is 1 exactly when int_id is not 4'h1. A source whose enable bit is 0 (bit 0 data available, 1 transmit empty, 2 line status, 3 modem, 4 timeout) affects neither output.
- R9: The data-available source is active while fifo_level >= trig_level and inactive once the level falls below the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_en | input | 5 | Per-source interrupt enables |
| dma_en | input | 1 | Receive DMA requests enabled |
| fifo_level | input | LVL_W | Entries held in the receive FIFO |
| trig_level | input | LVL_W | Receive trigger threshold |
| push | input | 1 | Entry written to the FIFO this cycle |
| push_flags | input | 3 | Error flags of the written entry |
| pop | input | 1 | Head entry read from the FIFO this cycle |
| head_flags | input | 3 | Error flags of the entry at the read side |
| char_to | input | 1 | Character-timeout strobe |
| tx_empty | input | 1 | Transmitter holding side empty |
| modem_chg | input | 1 | Modem status change pending |
| dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt request |
| int_id | output | 4 | Code of highest-priority pending source |
| rx_err_sum | output | 1 | At least one FIFO entry carries an error |

## Verification
The priority encoder is driven with static patterns. These cover every source alone, all sources at once, and each source with its enable cleared. Together they separate a wrong priority order from a missing mask. Level and threshold patterns set exactly equal, one below and at full depth probe the comparison edge shared by data-available and DMA. Sequences push and pop erroneous and clean entries, which separates the head-only line-status rule from the whole-FIFO summary that gates DMA and forces the error interrupt. Timeout sequences, including a strobe that coincides with a pop, show whether timeout blocks DMA and how the latch resolves the collision.

// File: rtl/uart_rx_svc_pkg.sv
package uart_rx_svc_pkg;
  localparam int NSRC  = 5;
  localparam int NFLAG = 3;

  // enable word bit positions
  localparam int EN_RDA = 0;
  localparam int EN_TXE = 1;
  localparam int EN_LS  = 2;
  localparam int EN_MS  = 3;
  localparam int EN_TO  = 4;

  // priority slots, 0 is highest
  localparam int P_LS  = 0;
  localparam int P_RDA = 1;
  localparam int P_TO  = 2;
  localparam int P_TXE = 3;
  localparam int P_MS  = 4;

  typedef enum logic [3:0] {
    ID_MS   = 4'h0,
    ID_NONE = 4'h1,
    ID_TXE  = 4'h2,
    ID_RDA  = 4'h4,
    ID_LS   = 4'h6,
    ID_TO   = 4'hC
  } int_id_e;

  function automatic int_id_e slot_code(input int idx);
    case (idx)
      P_LS:    slot_code = ID_LS;
      P_RDA:   slot_code = ID_RDA;
      P_TO:    slot_code = ID_TO;
      P_TXE:   slot_code = ID_TXE;
      P_MS:    slot_code = ID_MS;
      default: slot_code = ID_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_svc_rstsync.sv
module uart_rx_svc_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_svc_errcnt.sv
module uart_rx_svc_errcnt
  import uart_rx_svc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [NFLAG-1:0] push_flags,
  input  logic             pop,
  input  logic [NFLAG-1:0] head_flags,
  output logic             err_any
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          inc, dec, cnt_en;

  assign inc    = push && (|push_flags) && (cnt_q != CNT_MAX);
  assign dec    = pop && (|head_flags) && (cnt_q != '0);
  assign cnt_en = inc ^ dec;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + 1'b1;
    else if (dec && !inc) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign err_any = (cnt_q != '0);
endmodule

// File: rtl/uart_rx_svc_tolatch.sv
module uart_rx_svc_tolatch (
  input  logic clk,
  input  logic rst_n,
  input  logic char_to,
  input  logic pop,
  output logic to_pend
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (char_to)  pend_d = 1'b1;
    else if (pop) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign to_pend = pend_q;
endmodule

// File: rtl/uart_rx_svc_prio.sv
module uart_rx_svc_prio
  import uart_rx_svc_pkg::*;
(
  input  logic [NSRC-1:0] src,
  output int_id_e         id
);
  always_comb begin
    id = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src[i]) id = slot_code(i);
    end
  end
endmodule

// File: rtl/uart_rx_svc.sv
module uart_rx_svc
  import uart_rx_svc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  int_en,
  input  logic             dma_en,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] trig_level,
  input  logic             push,
  input  logic [NFLAG-1:0] push_flags,
  input  logic             pop,
  input  logic [NFLAG-1:0] head_flags,
  input  logic             char_to,
  input  logic             tx_empty,
  input  logic             modem_chg,
  output logic             dma_req,
  output logic             irq,
  output logic [3:0]       int_id,
  output logic             rx_err_sum
);
  logic            rst_i;
  logic            err_any;
  logic            to_pend;
  logic            lvl_hit;
  logic [NSRC-1:0] src;
  int_id_e         id_d, id_q;
  logic            dma_d, dma_q, irq_d, irq_q;

  uart_rx_svc_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_i)
  );

  uart_rx_svc_errcnt #(.DEPTH(DEPTH)) u_err (
    .clk        (clk),
    .rst_n      (rst_i),
    .push       (push),
    .push_flags (push_flags),
    .pop        (pop),
    .head_flags (head_flags),
    .err_any    (err_any)
  );

  uart_rx_svc_tolatch u_to (
    .clk     (clk),
    .rst_n   (rst_i),
    .char_to (char_to),
    .pop     (pop),
    .to_pend (to_pend)
  );

  assign lvl_hit = (fifo_level >= trig_level);

  always_comb begin
    src        = '0;
    src[P_LS]  = (int_en[EN_LS] && (|head_flags) && (fifo_level != '0))
               || (dma_en && err_any);
    src[P_RDA] = int_en[EN_RDA] && lvl_hit;
    src[P_TO]  = int_en[EN_TO]  && to_pend;
    src[P_TXE] = int_en[EN_TXE] && tx_empty;
    src[P_MS]  = int_en[EN_MS]  && modem_chg;
  end

  uart_rx_svc_prio u_prio (
    .src (src),
    .id  (id_d)
  );

  always_comb begin
    irq_d = (id_d != ID_NONE);
    dma_d = dma_en && lvl_hit && !err_any && !to_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= ID_NONE;
      irq_q <= 1'b0;
      dma_q <= 1'b0;
    end else if (!rst_i) begin
      id_q  <= ID_NONE;
      irq_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      id_q  <= id_d;
      irq_q <= irq_d;
      dma_q <= dma_d;
    end
  end

  assign dma_req    = dma_q;
  assign irq        = irq_q;
  assign int_id     = id_q;
  assign rx_err_sum = err_any;
endmodule

// File: rtl/uart_rx_svc_chk.sv
module uart_rx_svc_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_i,
  input logic             dma_en,
  input logic [LVL_W-1:0] fifo_level,
  input logic [LVL_W-1:0] trig_level,
  input logic             push,
  input logic [2:0]       push_flags,
  input logic             rx_err_sum,
  input logic             to_pend,
  input logic             dma_req,
  input logic             irq,
  input logic [3:0]       int_id
);
  a_r2_dma_gated: assert property (@(posedge clk) disable iff (!rst_i)
    dma_req |-> ($past(dma_en) && ($past(fifo_level) >= $past(trig_level))));

  a_r2_err_blocks_dma: assert property (@(posedge clk) disable iff (!rst_i)
    rx_err_sum |=> !dma_req);

  a_r3_sum_needs_push: assert property (@(posedge clk) disable iff (!rst_i)
    (!rx_err_sum && !(push && (|push_flags))) |=> !rx_err_sum);

  a_r5_err_unmasked: assert property (@(posedge clk) disable iff (!rst_i)
    (dma_en && rx_err_sum) |=> (irq && int_id == 4'h6));

  a_r6_to_blocks_dma: assert property (@(posedge clk) disable iff (!rst_i)
    to_pend |=> !dma_req);

  a_r8_irq_matches_id: assert property (@(posedge clk) disable iff (!rst_i)
    irq == (int_id != 4'h1));
endmodule

bind uart_rx_svc uart_rx_svc_chk #(.LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .dma_en     (dma_en),
  .fifo_level (fifo_level),
  .trig_level (trig_level),
  .push       (push),
  .push_flags (push_flags),
  .rx_err_sum (rx_err_sum),
  .to_pend    (to_pend),
  .dma_req    (dma_req),
  .irq        (irq),
  .int_id     (int_id)
);

// File: tb/uart_rx_svc_bench.sv
module uart_rx_svc_bench;
  localparam int CLK_P = 10;
  localparam int LW    = 5;

  typedef struct packed {
    logic [4:0]    en;
    logic          dma;
    logic [LW-1:0] lvl;
    logic [LW-1:0] trig;
    logic [2:0]    head;
    logic          txe;
    logic          ms;
    logic          x_dma;
    logic          x_irq;
    logic [3:0]    x_id;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{5'b00000, 1'b0, 5'd0,  5'd4,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1},
    '{5'b00001, 1'b0, 5'd4,  5'd4,  3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'h4},
    '{5'b00001, 1'b0, 5'd3,  5'd4,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1},
    '{5'b00000, 1'b1, 5'd8,  5'd4,  3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 4'h1},
    '{5'b00000, 1'b1, 5'd2,  5'd4,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1},
    '{5'b11111, 1'b0, 5'd5,  5'd4,  3'b001, 1'b1, 1'b1, 1'b0, 1'b1, 4'h6},
    '{5'b11111, 1'b0, 5'd5,  5'd4,  3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 4'h4},
    '{5'b11111, 1'b0, 5'd1,  5'd4,  3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 4'h2},
    '{5'b11111, 1'b0, 5'd0,  5'd4,  3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0},
    '{5'b00000, 1'b0, 5'd1,  5'd4,  3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 4'h1},
    '{5'b00100, 1'b0, 5'd1,  5'd4,  3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 4'h6},
    '{5'b00100, 1'b0, 5'd1,  5'd4,  3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1},
    '{5'b00100, 1'b0, 5'd0,  5'd4,  3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1},
    '{5'b01000, 1'b0, 5'd0,  5'd4,  3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0},
    '{5'b00001, 1'b1, 5'd16, 5'd16, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 4'h4}
  };

  logic          clk, rst_n;
  logic [4:0]    int_en;
  logic          dma_en, push, pop, char_to, tx_empty, modem_chg;
  logic [LW-1:0] fifo_level, trig_level;
  logic [2:0]    push_flags, head_flags;
  logic          dma_req, irq, rx_err_sum;
  logic [3:0]    int_id;

  int n_chk  = 0;
  int n_fail = 0;

  uart_rx_svc #(.DEPTH(16), .LVL_W(LW)) u_uart_rx_svc (
    .clk(clk), .rst_n(rst_n), .int_en(int_en), .dma_en(dma_en),
    .fifo_level(fifo_level), .trig_level(trig_level), .push(push),
    .push_flags(push_flags), .pop(pop), .head_flags(head_flags),
    .char_to(char_to), .tx_empty(tx_empty), .modem_chg(modem_chg),
    .dma_req(dma_req), .irq(irq), .int_id(int_id), .rx_err_sum(rx_err_sum)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic outs(input string req, input logic d, input logic i, input logic [3:0] id);
    chk({req, " dma_req"}, 32'(dma_req), 32'(d));
    chk({req, " irq"},     32'(irq),     32'(i));
    chk({req, " int_id"},  32'(int_id),  32'(id));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; int_en = '0; dma_en = 1'b0; fifo_level = '0; trig_level = 5'd4;
    push = 1'b0; push_flags = '0; pop = 1'b0; head_flags = '0;
    char_to = 1'b0; tx_empty = 1'b0; modem_chg = 1'b0;
    settle(3);
    // R1: state under reset
    outs("R1 in reset", 1'b0, 1'b0, 4'h1);
    chk("R1 rx_err_sum", 32'(rx_err_sum), 32'd0);
    rst_n = 1'b1;
    dma_en = 1'b1; fifo_level = 5'd8;
    settle(1);
    // R1: reset release still synchronising
    outs("R1 after release", 1'b0, 1'b0, 4'h1);
    dma_en = 1'b0; fifo_level = '0;
    settle(4);

    // R2 R7 R8 R9: table walk
    for (int k = 0; k < NV; k++) begin
      int_en = VT[k].en; dma_en = VT[k].dma; fifo_level = VT[k].lvl;
      trig_level = VT[k].trig; head_flags = VT[k].head;
      tx_empty = VT[k].txe; modem_chg = VT[k].ms;
      settle(2);
      outs($sformatf("R7 R8 R9 R2 vec%0d", k), VT[k].x_dma, VT[k].x_irq, VT[k].x_id);
    end

    // R2: deassertion exactly one clock after level drops
    int_en = '0; dma_en = 1'b1; fifo_level = 5'd6; trig_level = 5'd4;
    head_flags = '0; tx_empty = 1'b0; modem_chg = 1'b0;
    settle(2);
    chk("R2 dma asserted", 32'(dma_req), 32'd1);
    fifo_level = 5'd3;
    settle(1);
    chk("R2 dma drops in one clock", 32'(dma_req), 32'd0);

    // R4: error entry not at head raises nothing without DMA
    dma_en = 1'b0; int_en = 5'b00100; fifo_level = 5'd3; trig_level = 5'd2;
    push = 1'b1; push_flags = 3'b010;
    settle(1);
    push = 1'b0; push_flags = '0;
    settle(2);
    chk("R3 sum set after push", 32'(rx_err_sum), 32'd1);
    outs("R4 error not at head", 1'b0, 1'b0, 4'h1);

    // R5: unmaskable error interrupt, R2 dma blocked by error
    int_en = '0; dma_en = 1'b1;
    settle(2);
    outs("R5 R2 error with dma", 1'b0, 1'b1, 4'h6);

    // R3: clean push and clean pop keep the summary
    push = 1'b1; pop = 1'b1; head_flags = '0;
    settle(1);
    push = 1'b0; pop = 1'b0;
    settle(2);
    chk("R3 sum holds", 32'(rx_err_sum), 32'd1);

    // R3: popping the erroneous head clears it
    head_flags = 3'b010; pop = 1'b1;
    settle(1);
    pop = 1'b0; head_flags = '0;
    settle(2);
    chk("R3 sum cleared", 32'(rx_err_sum), 32'd0);
    outs("R3 R2 dma resumes", 1'b1, 1'b0, 4'h1);

    // R6: timeout blocks DMA and reports its code
    int_en = 5'b10000; char_to = 1'b1;
    settle(1);
    char_to = 1'b0;
    settle(2);
    outs("R6 timeout pending", 1'b0, 1'b1, 4'hC);
    int_en = '0;
    settle(2);
    outs("R6 masked timeout still blocks dma", 1'b0, 1'b0, 4'h1);

    // R6: strobe and pop together leave it pending
    char_to = 1'b1; pop = 1'b1;
    settle(1);
    char_to = 1'b0; pop = 1'b0;
    settle(2);
    chk("R6 set wins over pop", 32'(dma_req), 32'd0);

    // R6: pop clears
    pop = 1'b1;
    settle(1);
    pop = 1'b0;
    settle(2);
    chk("R6 pop clears timeout", 32'(dma_req), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule